// File: doc/BRIEF.md
# Low-Power Mode Sequencing Controller

This block sets the power state of a small microcontroller core. Software chooses one of eight operating modes with a 3-bit code and a sleep strobe. The modes are the active mode, five retention sleep levels (S0 to S4) and two shutdown levels (a shallow one that keeps the real-time clock, and a deep one that keeps nothing). From the current mode, the block drives enable outputs for the CPU, the main clock, the subsystem clock, the auxiliary clock, the nonvolatile memory (on or standby), the fast and slow peripheral groups, the real-time clock domain and the supply supervisor.

While the core sleeps, the block watches a vector of wake event inputs. Each event is gated by a software mask and by a fixed set of sources that the current mode accepts. A qualified event in a retention level brings the core to active to run its interrupt. When the interrupt exits, the core drops back to the saved level unless software asks to stay awake. A qualified event in a shutdown level cannot resume the core. It raises a one-cycle system reset request instead and sets a sticky flag that records the cause.

Top module: `lpm_seq_ctrl`

## Requirements
- R1: Mode codes are 0 active, 1 S0, 2 S1, 3 S2, 4 S3, 5 S4, 6 shallow shutdown, 7 deep shutdown. In active, a `sleep_req` pulse with a nonzero `mode_code` makes `cur_mode` show that code after the next clock edge, and the enable outputs follow one edge later.
- R2: A `sleep_req` with code 0, or any `sleep_req` while the mode is not active, is ignored and `cur_mode` does not change.
- R3: `cpu_en` is 1 only in active. `mclk_en` is 1 only in active and S0.
- R4: `smclk_en` equals `!smclk_off` in active, S0 and S1, and is 0 in every deeper mode.
- R5: `aclk_en` and `lf_per_en` are 1 from active through S3 and 0 in S4 and both shutdown levels. `rtc_en` is 1 from active through S3 and in shallow shutdown, and 0 otherwise.
- R6: `nvm_on` is 1 in active, and in S0 when `nvm_lpm0_off` is 0. `nvm_stby` is 1 only in S1. Both are 0 in every other case.
- R7: `hf_per_en` is 1 in active, S0 and S1 and 0 from S2 onward.
- R8: `svs_en` is 1 in active, S0, S1 and shallow shutdown, equals `svs_opt_en` in S2, S3 and S4, and is 0 in deep shutdown.
- R9: Wake bits are 0 slow clock, 1 RTC, 2 I/O, 3 comparator, and 4 and up other sources. S0 and S1 accept all bits. S2 and S3 accept bits 0 to 3. S4 accepts bits 2 and 3. Shallow shutdown accepts bits 1 and 2. Deep shutdown accepts bit 2 only. An event counts only when its `wake_msk` bit is also 1.
- R10: A qualified wake in S0 to S4 sets `cur_mode` to 0 and pulses `irq_take` high for one cycle after the same edge. Events that are masked or not accepted leave the mode unchanged.
- R11: In active after such a wake, `irq_exit` with `stay_awake` 0 returns `cur_mode` to the saved level after the next edge. With `stay_awake` 1 the core stays active. `irq_exit` has no effect when no wake is being serviced.
- R12: A qualified wake in a shutdown level sets `cur_mode` to 0, pulses `sys_rst` for one cycle and sets `shdn_wake_flag`. The flag stays 1 until `rst_n` is asserted.
- R13: After reset, `cur_mode` is 0, all enables are 1 except `nvm_stby`, and `irq_take`, `sys_rst` and `shdn_wake_flag` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode_code | input | 3 | Requested mode code |
| sleep_req | input | 1 | Strobe that latches `mode_code` |
| smclk_off | input | 1 | Software request to stop the subsystem clock |
| nvm_lpm0_off | input | 1 | Software request to switch off nonvolatile memory in S0 |
| svs_opt_en | input | 1 | Supervisor enable for S2 to S4 |
| wake_evt | input | 4+EXTRA_WAKE | Wake event inputs |
| wake_msk | input | 4+EXTRA_WAKE | Per-event wake enable mask |
| irq_exit | input | 1 | Interrupt return strobe |
| stay_awake | input | 1 | Cancels the return to the saved level on `irq_exit` |
| cpu_en | output | 1 | CPU enable |
| mclk_en | output | 1 | Main clock enable |
| smclk_en | output | 1 | Subsystem clock enable |
| aclk_en | output | 1 | Auxiliary clock enable |
| nvm_on | output | 1 | Nonvolatile memory fully on |
| nvm_stby | output | 1 | Nonvolatile memory in standby |
| hf_per_en | output | 1 | Fast peripheral group enable |
| lf_per_en | output | 1 | Slow peripheral group enable |
| rtc_en | output | 1 | Real-time clock domain enable |
| svs_en | output | 1 | Supply supervisor enable |
| irq_take | output | 1 | One-cycle pulse: wake to service an interrupt |
| sys_rst | output | 1 | One-cycle pulse: system reset after a shutdown wake |
| cur_mode | output | 3 | Current mode code |
| shdn_wake_flag | output | 1 | Sticky flag: a shutdown wake has occurred |

## Verification
A sleep strobe, a wake event or an interrupt exit changes `cur_mode`, `irq_take` and `sys_rst` at the first rising edge after the input is applied. The enable outputs, including the effect of the software control bits, change one edge after `cur_mode`. The bench drives inputs on the falling edge and samples pulses and the mode at the next falling edge. It waits one more falling edge before it compares the enable vector with a table it derives itself. For every mode and every wake bit it also checks that a source the mode does not accept leaves the mode unchanged.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [2:0] {
        MODE_ACT = 3'd0,
        MODE_S0  = 3'd1,
        MODE_S1  = 3'd2,
        MODE_S2  = 3'd3,
        MODE_S3  = 3'd4,
        MODE_S4  = 3'd5,
        MODE_SDH = 3'd6,
        MODE_SDD = 3'd7
    } pwr_mode_e;

    // wake source bit positions
    localparam int WK_SLOW  = 0;
    localparam int WK_RTC   = 1;
    localparam int WK_IO    = 2;
    localparam int WK_CMP   = 3;
    localparam int WK_FIXED = 4;

    typedef struct packed {
        logic cpu;
        logic mclk;
        logic smclk;
        logic aclk;
        logic nvm_on;
        logic nvm_stby;
        logic hf_per;
        logic lf_per;
        logic rtc;
        logic svs;
    } en_vec_t;

    localparam en_vec_t EN_RESET = '{cpu: 1'b1, mclk: 1'b1, smclk: 1'b1, aclk: 1'b1,
                                     nvm_on: 1'b1, nvm_stby: 1'b0, hf_per: 1'b1,
                                     lf_per: 1'b1, rtc: 1'b1, svs: 1'b1};

    typedef struct packed {
        pwr_mode_e mode;
        pwr_mode_e saved;
        logic      in_isr;
        logic      irq_take;
        logic      sys_rst;
        logic      shdn_flag;
    } fsm_st_t;

endpackage

// File: rtl/lpm_wake_filter.sv
module lpm_wake_filter
    import lpm_pkg::*;
#(
    parameter int WAKE_W = 6
) (
    input  pwr_mode_e         mode,
    input  logic [WAKE_W-1:0] evt,
    input  logic [WAKE_W-1:0] msk,
    output logic              hit
);

    logic [WAKE_W-1:0] allow;

    for (genvar b = 0; b < WAKE_W; b++) begin : g_src
        if (b == WK_SLOW) begin : g_slow
            assign allow[b] = (mode == MODE_S0) || (mode == MODE_S1) ||
                              (mode == MODE_S2) || (mode == MODE_S3);
        end else if (b == WK_RTC) begin : g_rtc
            assign allow[b] = (mode == MODE_S0) || (mode == MODE_S1) ||
                              (mode == MODE_S2) || (mode == MODE_S3) ||
                              (mode == MODE_SDH);
        end else if (b == WK_IO) begin : g_io
            assign allow[b] = (mode != MODE_ACT);
        end else if (b == WK_CMP) begin : g_cmp
            assign allow[b] = (mode == MODE_S0) || (mode == MODE_S1) ||
                              (mode == MODE_S2) || (mode == MODE_S3) ||
                              (mode == MODE_S4);
        end else begin : g_other
            assign allow[b] = (mode == MODE_S0) || (mode == MODE_S1);
        end
    end

    assign hit = |(evt & msk & allow);

endmodule

// File: rtl/lpm_enable_decode.sv
module lpm_enable_decode
    import lpm_pkg::*;
(
    input  pwr_mode_e mode,
    input  logic      smclk_off,
    input  logic      nvm_lpm0_off,
    input  logic      svs_opt_en,
    output en_vec_t   en
);

    logic upto_s1;
    logic upto_s3;

    always_comb begin
        upto_s1 = (mode == MODE_ACT) || (mode == MODE_S0) || (mode == MODE_S1);
        upto_s3 = upto_s1 || (mode == MODE_S2) || (mode == MODE_S3);

        en          = '0;
        en.cpu      = (mode == MODE_ACT);
        en.mclk     = (mode == MODE_ACT) || (mode == MODE_S0);
        en.smclk    = upto_s1 && !smclk_off;
        en.aclk     = upto_s3;
        en.nvm_on   = (mode == MODE_ACT) || ((mode == MODE_S0) && !nvm_lpm0_off);
        en.nvm_stby = (mode == MODE_S1);
        en.hf_per   = upto_s1;
        en.lf_per   = upto_s3;
        en.rtc      = upto_s3 || (mode == MODE_SDH);
        unique case (mode)
            MODE_S2, MODE_S3, MODE_S4: en.svs = svs_opt_en;
            MODE_SDD:                  en.svs = 1'b0;
            default:                   en.svs = 1'b1;
        endcase
    end

endmodule

// File: rtl/lpm_mode_fsm.sv
module lpm_mode_fsm
    import lpm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      sleep_req,
    input  logic [2:0] mode_code,
    input  logic      wake_hit,
    input  logic      irq_exit,
    input  logic      stay_awake,
    output fsm_st_t   st
);

    fsm_st_t st_d, st_q;
    logic    shutdown_lvl;

    always_comb begin
        shutdown_lvl = (st_q.mode == MODE_SDH) || (st_q.mode == MODE_SDD);
        st_d          = st_q;
        st_d.irq_take = 1'b0;
        st_d.sys_rst  = 1'b0;

        if (st_q.mode == MODE_ACT) begin
            if (sleep_req && (mode_code != 3'd0)) begin
                st_d.mode   = pwr_mode_e'(mode_code);
                st_d.saved  = pwr_mode_e'(mode_code);
                st_d.in_isr = 1'b0;
            end else if (irq_exit && st_q.in_isr) begin
                st_d.in_isr = 1'b0;
                if (!stay_awake) begin
                    st_d.mode = st_q.saved;
                end
            end
        end else if (wake_hit) begin
            st_d.mode = MODE_ACT;
            if (shutdown_lvl) begin
                st_d.saved     = MODE_ACT;
                st_d.in_isr    = 1'b0;
                st_d.sys_rst   = 1'b1;
                st_d.shdn_flag = 1'b1;
            end else begin
                st_d.in_isr   = 1'b1;
                st_d.irq_take = 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_ACT, saved: MODE_ACT, in_isr: 1'b0,
                      irq_take: 1'b0, sys_rst: 1'b0, shdn_flag: 1'b0};
        end else begin
            st_q <= st_d;
        end
    end

    assign st = st_q;

endmodule

// File: rtl/lpm_seq_ctrl.sv
module lpm_seq_ctrl
    import lpm_pkg::*;
#(
    parameter int EXTRA_WAKE = 2,
    localparam int WAKE_W = WK_FIXED + EXTRA_WAKE
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [2:0]        mode_code,
    input  logic              sleep_req,
    input  logic              smclk_off,
    input  logic              nvm_lpm0_off,
    input  logic              svs_opt_en,
    input  logic [WAKE_W-1:0] wake_evt,
    input  logic [WAKE_W-1:0] wake_msk,
    input  logic              irq_exit,
    input  logic              stay_awake,
    output logic              cpu_en,
    output logic              mclk_en,
    output logic              smclk_en,
    output logic              aclk_en,
    output logic              nvm_on,
    output logic              nvm_stby,
    output logic              hf_per_en,
    output logic              lf_per_en,
    output logic              rtc_en,
    output logic              svs_en,
    output logic              irq_take,
    output logic              sys_rst,
    output logic [2:0]        cur_mode,
    output logic              shdn_wake_flag
);

    fsm_st_t st;
    logic    wake_hit;
    en_vec_t en_d, en_q;

    lpm_wake_filter #(.WAKE_W(WAKE_W)) u_filter (
        .mode (st.mode),
        .evt  (wake_evt),
        .msk  (wake_msk),
        .hit  (wake_hit)
    );

    lpm_mode_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .sleep_req  (sleep_req),
        .mode_code  (mode_code),
        .wake_hit   (wake_hit),
        .irq_exit   (irq_exit),
        .stay_awake (stay_awake),
        .st         (st)
    );

    lpm_enable_decode u_decode (
        .mode         (st.mode),
        .smclk_off    (smclk_off),
        .nvm_lpm0_off (nvm_lpm0_off),
        .svs_opt_en   (svs_opt_en),
        .en           (en_d)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= EN_RESET;
        end else begin
            en_q <= en_d;
        end
    end

    assign cpu_en         = en_q.cpu;
    assign mclk_en        = en_q.mclk;
    assign smclk_en       = en_q.smclk;
    assign aclk_en        = en_q.aclk;
    assign nvm_on         = en_q.nvm_on;
    assign nvm_stby       = en_q.nvm_stby;
    assign hf_per_en      = en_q.hf_per;
    assign lf_per_en      = en_q.lf_per;
    assign rtc_en         = en_q.rtc;
    assign svs_en         = en_q.svs;
    assign irq_take       = st.irq_take;
    assign sys_rst        = st.sys_rst;
    assign cur_mode       = st.mode;
    assign shdn_wake_flag = st.shdn_flag;

endmodule

// File: rtl/lpm_seq_ctrl_chk.sv
module lpm_seq_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic [2:0] cur_mode,
    input logic       smclk_off,
    input logic       cpu_en,
    input logic       mclk_en,
    input logic       smclk_en,
    input logic       nvm_on,
    input logic       nvm_stby,
    input logic       irq_take,
    input logic       sys_rst,
    input logic       shdn_wake_flag
);

    assert_cpu_active_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_en |-> ($past(cur_mode) == 3'd0));

    assert_mclk_shallow_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
        mclk_en |-> ($past(cur_mode) <= 3'd1));

    assert_smclk_gate_R4: assert property (@(posedge clk) disable iff (!rst_n)
        smclk_en |-> (($past(cur_mode) <= 3'd2) && !$past(smclk_off)));

    assert_nvm_exclusive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(nvm_on && nvm_stby));

    assert_wake_pulse_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |-> ((cur_mode == 3'd0) && ($past(cur_mode) >= 3'd1) &&
                      ($past(cur_mode) <= 3'd5)));

    assert_irq_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        irq_take |=> !irq_take);

    assert_reset_source_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> ((cur_mode == 3'd0) && ($past(cur_mode) >= 3'd6)));

    assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        $past(shdn_wake_flag) |-> shdn_wake_flag);

    assert_flag_on_reset_R12: assert property (@(posedge clk) disable iff (!rst_n)
        sys_rst |-> shdn_wake_flag);

endmodule

bind lpm_seq_ctrl lpm_seq_ctrl_chk u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .cur_mode       (cur_mode),
    .smclk_off      (smclk_off),
    .cpu_en         (cpu_en),
    .mclk_en        (mclk_en),
    .smclk_en       (smclk_en),
    .nvm_on         (nvm_on),
    .nvm_stby       (nvm_stby),
    .irq_take       (irq_take),
    .sys_rst        (sys_rst),
    .shdn_wake_flag (shdn_wake_flag)
);

// File: tb/tb_lpm_seq_ctrl.sv
`timescale 1ns/1ps
module tb_lpm_seq_ctrl;

    localparam int EXTRA = 2;
    localparam int W     = 4 + EXTRA;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [2:0]   mode_code = '0;
    logic         sleep_req = 1'b0;
    logic         smclk_off = 1'b0;
    logic         nvm_lpm0_off = 1'b0;
    logic         svs_opt_en = 1'b0;
    logic [W-1:0] wake_evt = '0;
    logic [W-1:0] wake_msk = '1;
    logic         irq_exit = 1'b0;
    logic         stay_awake = 1'b0;
    logic cpu_en, mclk_en, smclk_en, aclk_en, nvm_on, nvm_stby;
    logic hf_per_en, lf_per_en, rtc_en, svs_en, irq_take, sys_rst, shdn_wake_flag;
    logic [2:0] cur_mode;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    lpm_seq_ctrl #(.EXTRA_WAKE(EXTRA)) dut (
        .clk(clk), .rst_n(rst_n), .mode_code(mode_code), .sleep_req(sleep_req),
        .smclk_off(smclk_off), .nvm_lpm0_off(nvm_lpm0_off), .svs_opt_en(svs_opt_en),
        .wake_evt(wake_evt), .wake_msk(wake_msk), .irq_exit(irq_exit),
        .stay_awake(stay_awake), .cpu_en(cpu_en), .mclk_en(mclk_en),
        .smclk_en(smclk_en), .aclk_en(aclk_en), .nvm_on(nvm_on), .nvm_stby(nvm_stby),
        .hf_per_en(hf_per_en), .lf_per_en(lf_per_en), .rtc_en(rtc_en),
        .svs_en(svs_en), .irq_take(irq_take), .sys_rst(sys_rst),
        .cur_mode(cur_mode), .shdn_wake_flag(shdn_wake_flag)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // {cpu,mclk,smclk,aclk,nvm_on,nvm_stby,hf,lf,rtc,svs}
    function automatic logic [9:0] exp_en(input int m, input logic so, input logic no,
                                          input logic sv);
        logic [9:0] v;
        v[9] = (m == 0);
        v[8] = (m <= 1);
        v[7] = (m <= 2) && !so;
        v[6] = (m <= 4);
        v[5] = (m == 0) || ((m == 1) && !no);
        v[4] = (m == 2);
        v[3] = (m <= 2);
        v[2] = (m <= 4);
        v[1] = (m <= 4) || (m == 6);
        v[0] = (m <= 2) ? 1'b1 : (m <= 5) ? sv : (m == 6);
        return v;
    endfunction

    function automatic logic accepts(input int m, input int b);
        case (m)
            1, 2:    return 1'b1;
            3, 4:    return b <= 3;
            5:       return (b == 2) || (b == 3);
            6:       return (b == 1) || (b == 2);
            7:       return b == 2;
            default: return 1'b0;
        endcase
    endfunction

    function automatic logic [9:0] en_now();
        return {cpu_en, mclk_en, smclk_en, aclk_en, nvm_on, nvm_stby,
                hf_per_en, lf_per_en, rtc_en, svs_en};
    endfunction

    task automatic enter_mode(input int m);
        mode_code = 3'(m);
        sleep_req = 1'b1;
        @(negedge clk);
        sleep_req = 1'b0;
    endtask

    task automatic wake_bit(input int b);
        wake_evt = '0;
        wake_evt[b] = 1'b1;
        @(negedge clk);
        wake_evt = '0;
    endtask

    task automatic end_isr(input logic stay);
        irq_exit = 1'b1;
        stay_awake = stay;
        @(negedge clk);
        irq_exit = 1'b0;
        stay_awake = 1'b0;
    endtask

    task automatic t_reset();
        check("R13 mode", cur_mode, 0);
        check("R13 enables", en_now(), 10'b1111101111);
        check("R13 irq_take", irq_take, 0);
        check("R13 sys_rst", sys_rst, 0);
        check("R13 flag", shdn_wake_flag, 0);
    endtask

    task automatic t_enables(input logic so, input logic no, input logic sv);
        smclk_off = so; nvm_lpm0_off = no; svs_opt_en = sv;
        @(negedge clk);
        @(negedge clk);
        check("R3-R8 active vector", en_now(), exp_en(0, so, no, sv));
        for (int m = 1; m < 8; m++) begin
            enter_mode(m);
            check("R1 mode entry", cur_mode, m);
            @(negedge clk);
            check($sformatf("R3 R4 R5 R6 R7 R8 vector mode %0d", m), en_now(),
                  exp_en(m, so, no, sv));
            wake_bit(2);
            check("R10 R12 io wake", cur_mode, 0);
            if (m < 6) end_isr(1'b1);
            @(negedge clk);
        end
        smclk_off = 1'b0; nvm_lpm0_off = 1'b0; svs_opt_en = 1'b0;
        @(negedge clk);
    endtask

    task automatic t_wake_masks();
        for (int m = 1; m < 8; m++) begin
            for (int b = 0; b < W; b++) begin
                logic ok;
                ok = accepts(m, b);
                enter_mode(m);
                wake_bit(b);
                check($sformatf("R9 mode %0d bit %0d", m, b), cur_mode, ok ? 0 : m);
                if (m < 6) check("R10 irq_take", irq_take, ok);
                else       check("R12 sys_rst", sys_rst, ok);
                if (!ok) wake_bit(2);
                if (m < 6) end_isr(1'b1);
            end
        end
    endtask

    task automatic t_mask_gate();
        enter_mode(1);
        wake_msk = '0;
        wake_evt = '1;
        repeat (3) @(negedge clk);
        check("R9 masked mode", cur_mode, 1);
        check("R10 masked no irq", irq_take, 0);
        wake_evt = '0;
        wake_msk = '1;
        wake_bit(4);
        check("R10 other source wake", cur_mode, 0);
        check("R10 irq pulse", irq_take, 1);
        @(negedge clk);
        check("R10 pulse one cycle", irq_take, 0);
        end_isr(1'b1);
    endtask

    task automatic t_return();
        enter_mode(4);
        wake_bit(3);
        check("R10 cmp wake", cur_mode, 0);
        @(negedge clk);
        check("R10 active vector in isr", en_now(), exp_en(0, 0, 0, 0));
        end_isr(1'b0);
        check("R11 auto return", cur_mode, 4);
        @(negedge clk);
        check("R11 return vector", en_now(), exp_en(4, 0, 0, 0));
        wake_bit(0);
        end_isr(1'b1);
        check("R11 stay awake", cur_mode, 0);
        end_isr(1'b0);
        check("R11 exit without isr ignored", cur_mode, 0);
        enter_mode(0);
        check("R2 code zero ignored", cur_mode, 0);
        enter_mode(3);
        enter_mode(5);
        check("R2 strobe in sleep ignored", cur_mode, 3);
        wake_bit(2);
        end_isr(1'b0);
        check("R11 saved level kept", cur_mode, 3);
        wake_bit(2);
        end_isr(1'b1);
    endtask

    task automatic t_shutdown();
        enter_mode(7);
        wake_bit(1);
        check("R9 deep rejects rtc", cur_mode, 7);
        check("R12 no reset", sys_rst, 0);
        wake_bit(2);
        check("R12 reset pulse", sys_rst, 1);
        check("R12 mode active", cur_mode, 0);
        check("R12 flag set", shdn_wake_flag, 1);
        check("R12 no irq", irq_take, 0);
        @(negedge clk);
        check("R12 pulse one cycle", sys_rst, 0);
        end_isr(1'b0);
        check("R12 no resume after shutdown", cur_mode, 0);
        check("R12 flag sticky", shdn_wake_flag, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_enables(1'b0, 1'b0, 1'b0);
        t_enables(1'b1, 1'b1, 1'b1);
        t_enables(1'b1, 1'b0, 1'b1);
        t_wake_masks();
        t_mask_gate();
        t_return();
        t_shutdown();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_err++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

endmodule